// File: doc/BRIEF.md
# Byte-Lane Masked Memory Port

This block is a synthesizable behavioural model of the data side of an asynchronous 16-bit memory port. A small internal array is read and written through active-low chip select, write strobe and output enable controls, plus two active-low byte-lane enables: one for the lower byte and one for the upper byte. A fast system clock samples every control, address and data input. The block acts on the sampled history of those inputs, never on raw edges.

On a read, only the lanes whose byte enable is low are driven. Each lane has its own output-enable bit, so a tri-state pad can be attached outside the block. On a write, only the enabled lanes of the addressed word change. The data and the address are taken at the moment the write window closes. The window is open while chip select, write strobe and at least one byte enable are all low. It closes on the first sampled rise of any of the four controls. A lane whose enable is still low after that rise keeps the window open, and it is written again at its own later rise.

Top module: `bytelane_mem_port`

## Requirements
- R1: While chip select is low, the write strobe is high and the output enable is low, each lane whose byte enable is low has its `dq_oe` bit at 1 and carries the stored byte of the addressed word. Lane 0 is `dq_out[7:0]`, controlled by `lb_n` and `dq_oe[0]`. Lane 1 is `dq_out[15:8]`, controlled by `ub_n` and `dq_oe[1]`.
- R2: Each lane whose byte enable is high has its `dq_oe` bit at 0, and that lane of `dq_out` reads as zero.
- R3: A write changes only the lanes whose byte enable was low while the window was open. The other lane of the stored word keeps its value.
- R4: The data and the address stored are those sampled on the clock where the first rise of chip select, write strobe, lower enable or upper enable is seen. Values presented before or after that sample are not stored.
- R5: With both byte enables high, the port neither drives (`dq_oe` = 0) nor stores data, even while chip select and write strobe are low.
- R6: While the write strobe is low, `dq_oe` is 0 whatever the output enable is.
- R7: With chip select high or output enable high, `dq_oe` is 0.
- R8: Synchronous active-low reset clears `dq_oe` and `dq_out` to zero.
- R9: `dq_oe` and `dq_out` follow the inputs sampled two clock edges earlier.
- R10: If one byte enable rises while the other stays low, with chip select and write strobe still low, both lanes are written at that rise. The window then stays open for the remaining lane, and that lane is written again with the data present at its own rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower byte lane enable, active low |
| ub_n | input | 1 | Upper byte lane enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 2*LANE_W | Data from the bus |
| dq_out | output | 2*LANE_W | Data to the bus, zero on undriven lanes |
| dq_oe | output | 2 | Per-lane drive enable for the bus pads |

## Verification
Inputs are registered once into a sample stage. The read outputs are registered from that stage, so a read result appears after the second rising edge that follows the stimulus. A write is committed to the array one edge after the closing rise is sampled. The bench drives every input on a falling edge and samples `dq_oe` and `dq_out` on the falling edge after the second rising edge. Write results are read back only after idle cycles, so the commit edge has passed before the check. The latency check also samples after one edge, to confirm the output has not yet changed.

// File: rtl/bl_port_pkg.sv
// Shared constants and types for the byte-lane memory port.
package bl_port_pkg;
    // Number of byte lanes on the port (lower and upper).
    localparam int NUM_LANES = 2;

    // Sampled control group shared by all lanes.
    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } ctl_t;

    // Idle value for the control group (everything deasserted).
    localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
endpackage

// File: rtl/bl_ctl_sampler.sv
// Control sampler: registers the port inputs once (current sample)
// and keeps the sample before it (previous sample). From the pair it
// decodes per-lane read activity and the write-close event.
// Assumes inputs are stable around the sampling clock edge; a close
// is the first rise of any control after an open window.
module bl_ctl_sampler
    import bl_port_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = NUM_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ctl_t                 ctl_in,
    input  logic [NUM_LANES-1:0] ben_n_in,
    input  logic [ADDR_W-1:0]    addr_in,
    input  logic [DATA_W-1:0]    din_in,
    output logic [NUM_LANES-1:0] rd_lane,
    output logic [ADDR_W-1:0]    rd_addr,
    output logic [NUM_LANES-1:0] wr_lane,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [DATA_W-1:0]    wr_data
);
    ctl_t                 cur_ctl, prv_ctl;
    logic [NUM_LANES-1:0] cur_ben, prv_ben;
    logic [ADDR_W-1:0]    cur_addr;
    logic [DATA_W-1:0]    cur_din;
    logic                 prv_open, any_rise, close_evt;

    // Capture the current sample and age it into the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ctl  <= CTL_IDLE;
            prv_ctl  <= CTL_IDLE;
            cur_ben  <= '1;
            prv_ben  <= '1;
            cur_addr <= '0;
            cur_din  <= '0;
        end else begin
            prv_ctl  <= cur_ctl;
            prv_ben  <= cur_ben;
            cur_ctl  <= ctl_in;
            cur_ben  <= ben_n_in;
            cur_addr <= addr_in;
            cur_din  <= din_in;
        end
    end

    // Decode the window state and the first rising control.
    always_comb begin
        prv_open  = !prv_ctl.ce_n && !prv_ctl.we_n && (prv_ben != '1);
        any_rise  = (cur_ctl.ce_n && !prv_ctl.ce_n) ||
                    (cur_ctl.we_n && !prv_ctl.we_n) ||
                    (|(cur_ben & ~prv_ben));
        close_evt = prv_open && any_rise;
    end

    // Per-lane read and write qualifiers.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign rd_lane[g] = !cur_ctl.ce_n && cur_ctl.we_n &&
                            !cur_ctl.oe_n && !cur_ben[g];
        assign wr_lane[g] = close_evt && !prv_ben[g];
    end

    assign rd_addr = cur_addr;
    assign wr_addr = cur_addr;
    assign wr_data = cur_din;
endmodule

// File: rtl/bl_lane_array.sv
// Storage array split into one memory per byte lane, so each lane has
// its own write enable. Not reset: contents are undefined until written.
// Assumes at most one write per lane per clock.
module bl_lane_array
    import bl_port_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = NUM_LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] wr_lane,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Store this lane's byte when its write qualifier is set.
        always_ff @(posedge clk) begin
            if (wr_lane[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        // Asynchronous read of this lane.
        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];

        // R3
        lane_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_lane[g] |=> mem[$past(wr_addr)] == $past(wr_data[g*LANE_W +: LANE_W]));
    end
endmodule

// File: rtl/bl_lane_drive.sv
// Output stage: registers per-lane drive enables and data. A lane that
// is not driven presents zero data.
module bl_lane_drive
    import bl_port_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int DATA_W = NUM_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] rd_lane,
    input  logic [DATA_W-1:0]    rd_data,
    output logic [DATA_W-1:0]    dq_out,
    output logic [NUM_LANES-1:0] dq_oe
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        // Register this lane's enable and its data (zero when idle).
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dq_oe[g]                     <= 1'b0;
                dq_out[g*LANE_W +: LANE_W]   <= '0;
            end else begin
                dq_oe[g]                     <= rd_lane[g];
                dq_out[g*LANE_W +: LANE_W]   <= rd_lane[g] ?
                                                rd_data[g*LANE_W +: LANE_W] : '0;
            end
        end

        // R2
        idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !dq_oe[g] |-> dq_out[g*LANE_W +: LANE_W] == '0);
    end
endmodule

// File: rtl/bytelane_mem_port.sv
// Byte-lane masked asynchronous memory port model. Samples all inputs
// on clk, reads with per-lane drive enables, writes enabled lanes at
// the close of the write window. Read results lag inputs by two edges.
module bytelane_mem_port
    import bl_port_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = NUM_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_n,
    input  logic                 we_n,
    input  logic                 oe_n,
    input  logic                 lb_n,
    input  logic                 ub_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    dq_in,
    output logic [DATA_W-1:0]    dq_out,
    output logic [NUM_LANES-1:0] dq_oe
);
    ctl_t                 ctl_in;
    logic [NUM_LANES-1:0] rd_lane, wr_lane;
    logic [ADDR_W-1:0]    rd_addr, wr_addr;
    logic [DATA_W-1:0]    wr_data, rd_data;

    assign ctl_in = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n};

    bl_ctl_sampler #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in), .ben_n_in({ub_n, lb_n}),
        .addr_in(addr), .din_in(dq_in), .rd_lane(rd_lane), .rd_addr(rd_addr),
        .wr_lane(wr_lane), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    bl_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .wr_lane(wr_lane), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    bl_lane_drive #(.LANE_W(LANE_W)) u_drv (
        .clk(clk), .rst_n(rst_n), .rd_lane(rd_lane), .rd_data(rd_data),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // Count edges since reset release so that port history checks only
    // look back over cycles that are out of reset.
    logic [1:0] settle_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                settle_cnt <= '0;
        else if (settle_cnt != 2'd2) settle_cnt <= settle_cnt + 2'd1;
    end

    // R6
    we_over_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_cnt == 2'd2 && !$past(we_n, 2)) |-> dq_oe == '0);

    // R7
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_cnt == 2'd2 && ($past(ce_n, 2) || $past(oe_n, 2))) |-> dq_oe == '0);

    // R5
    no_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_cnt == 2'd2 && $past(lb_n, 2) && $past(ub_n, 2)) |-> dq_oe == '0);
endmodule

// File: tb/bytelane_mem_port_tb_top.sv
// Directed bench for the byte-lane memory port.
module bytelane_mem_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 4;
    localparam int LANE_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bytelane_mem_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic go_idle();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
    endtask

    // Write with junk data before and after the closing rise of we_n.
    task automatic do_write(input logic [3:0] a, input logic [15:0] d,
                            input logic l, input logic u);
        @(negedge clk);
        addr = a; dq_in = 16'hFFFF; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        lb_n = l; ub_n = u;
        @(negedge clk); dq_in = d;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); dq_in = 16'h1111; addr = a + 4'd1;
        @(negedge clk); go_idle();
        @(negedge clk);
    endtask

    // Start a read; return at the negedge after the second rising edge.
    task automatic do_read(input logic [3:0] a, input logic l, input logic u);
        @(negedge clk);
        addr = a; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; lb_n = l; ub_n = u;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 oe after reset", {14'd0, dq_oe}, 16'h0000);
        check("R8 data after reset", dq_out, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_full_rw();
        do_write(4'd3, 16'hA55A, 1'b0, 1'b0);
        do_write(4'd6, 16'h6666, 1'b0, 1'b0);
        do_read(4'd3, 1'b0, 1'b0);
        check("R1 both lanes oe", {14'd0, dq_oe}, 16'h0003);
        check("R1 both lanes data", dq_out, 16'hA55A);
        go_idle();
    endtask

    task automatic t_lane_mask();
        do_write(4'd3, 16'h1234, 1'b0, 1'b1);
        do_read(4'd3, 1'b0, 1'b0);
        check("R3 lower-only write", dq_out, 16'hA534);
        go_idle();
        do_write(4'd3, 16'hBEEF, 1'b1, 1'b0);
        do_read(4'd3, 1'b0, 1'b0);
        check("R3 upper-only write", dq_out, 16'hBE34);
        go_idle();
    endtask

    task automatic t_read_mask();
        do_read(4'd3, 1'b0, 1'b1);
        check("R2 lower-only oe", {14'd0, dq_oe}, 16'h0001);
        check("R2 lower-only data", dq_out, 16'h0034);
        go_idle();
        do_read(4'd3, 1'b1, 1'b0);
        check("R2 upper-only oe", {14'd0, dq_oe}, 16'h0002);
        check("R2 upper-only data", dq_out, 16'hBE00);
        go_idle();
    endtask

    task automatic t_capture();
        do_write(4'd5, 16'h0F0F, 1'b0, 1'b0);
        do_read(4'd5, 1'b0, 1'b0);
        check("R4 data at closing sample", dq_out, 16'h0F0F);
        go_idle();
        do_read(4'd6, 1'b0, 1'b0);
        check("R4 later address untouched", dq_out, 16'h6666);
        go_idle();
    endtask

    task automatic t_both_off();
        do_write(4'd5, 16'hDEAD, 1'b1, 1'b1);
        do_read(4'd5, 1'b0, 1'b0);
        check("R5 no store with both lanes off", dq_out, 16'h0F0F);
        go_idle();
        do_read(4'd5, 1'b1, 1'b1);
        check("R5 no drive with both lanes off", {14'd0, dq_oe}, 16'h0000);
        go_idle();
    endtask

    task automatic t_we_prio();
        @(negedge clk);
        addr = 4'd5; dq_in = 16'h0F0F; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        lb_n = 1'b0; ub_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R6 write strobe blocks drive", {14'd0, dq_oe}, 16'h0000);
        go_idle();
        @(negedge clk);
    endtask

    task automatic t_deselect();
        @(negedge clk);
        addr = 4'd5; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R7 chip select high", {14'd0, dq_oe}, 16'h0000);
        ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 output enable high", {14'd0, dq_oe}, 16'h0000);
        go_idle();
        @(negedge clk);
    endtask

    task automatic t_latency();
        @(negedge clk);
        addr = 4'd5; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
        @(negedge clk);
        check("R9 not yet driven after one edge", {14'd0, dq_oe}, 16'h0000);
        @(negedge clk);
        check("R9 driven after two edges", {14'd0, dq_oe}, 16'h0003);
        go_idle();
        @(negedge clk);
    endtask

    task automatic t_split();
        @(negedge clk);
        addr = 4'd9; dq_in = 16'h1122; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        lb_n = 1'b0; ub_n = 1'b0;
        @(negedge clk); lb_n = 1'b1;
        @(negedge clk); dq_in = 16'h3344;
        @(negedge clk); ub_n = 1'b1;
        @(negedge clk); dq_in = 16'h5555; go_idle();
        @(negedge clk);
        do_read(4'd9, 1'b0, 1'b0);
        check("R10 split close", dq_out, 16'h3322);
        go_idle();
    endtask

    initial begin
        t_reset();
        t_full_rw();
        t_lane_mask();
        t_read_mask();
        t_capture();
        t_both_off();
        t_we_prio();
        t_deselect();
        t_latency();
        t_split();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired got=%0d exp=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule